// File: doc/BRIEF.md
# Transactional Snoop Responder

This block is the bus-watching half of one processor node in a shared-bus multiprocessor that supports hardware transactions. Each node keeps two caches: a direct-mapped regular cache and a small fully-associative transactional cache. Every entry of the transactional cache carries a tag: free, stable (committed data), old (the committed copy kept while a transaction runs) or new (the tentative copy). When another node puts a read, read-exclusive, transactional read or transactional read-exclusive cycle on the bus, the responder looks the line up in both caches. It then supplies data, refuses the cycle with a busy response, or stays silent, and it updates the line state.

While the local transaction is live, a transactional cycle that reaches a line the node holds is refused unless it is a shared transactional read of a line that is clean and shared. This is how conflicting transactions are pushed to abort. The responder also reports whether any cache answered, so that main memory answers a read only when no cache did. A modified line handed out on a shared read is flagged for memory to capture as well. Lines are loaded through a plain fill port that stands in for the processor side.

The response appears on the registered outputs in the cycle after the request is sampled. State changes take effect at the same clock edge.

Top module: `txsnoop_responder`

## Requirements
- R1: While reset is asserted and right after it is released, every response output is 0.
- R2: A request sampled at a clock edge produces its response (rsp_valid=1) after that edge, for exactly one cycle. A cycle without a request leaves rsp_valid, rsp_cache and rsp_mem at 0.
- R3: In the regular cache, a read (kind 0) or a transactional read (kind 3) to a held line supplies that line's data. A line in VALID (state 1) keeps its state. A line in DIRTY (2) or RESERVED (3) moves to VALID.
- R4: In the regular cache, a read-exclusive (kind 1) or transactional read-exclusive (kind 4) to a held line supplies the data and invalidates the line, so a later read of that address finds nothing.
- R5: A request for an address held in neither cache, or held only in state INVALID (0) or with tag free (0), gets no data and no busy, and memory answers it (rsp_mem=1).
- R6: When the local transaction is not live, or the cycle is kind 0 or 1, the transactional cache behaves like the regular cache but considers only entries tagged stable (1). Entries tagged old (2) or new (3) are ignored. An exclusive read frees the entry.
- R7: When the local transaction is live, a transactional read (kind 3) to an address whose held entries are all VALID supplies the data of the committed copy (tag stable or old) and changes no state.
- R8: When the local transaction is live, any other transactional cycle to an address held in the transactional cache is answered with busy (rsp_busy=1). Memory does not answer it, and no line in either cache changes state.
- R9: Memory answers a read-type cycle (kinds 0, 1, 3, 4) only when no cache supplied data or busy. A write-back (kind 2) is always answered by memory and never changes or reads a cache line.
- R10: rsp_flush is 1 only when a DIRTY line is supplied on kind 0 or kind 3. An exclusive read of a DIRTY line hands it over without a flush.
- R11: When busy and data are both possible, busy wins: rsp_busy=1 forces rsp_supply=0, even when the regular cache holds the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Load one cache line this cycle |
| fill_txn | input | 1 | 1 = load goes to the transactional cache, 0 = regular cache |
| fill_slot | input | 2 | Transactional cache entry to load |
| fill_addr | input | 8 | Line address being loaded |
| fill_state | input | 2 | Line state: 0 INVALID, 1 VALID, 2 DIRTY, 3 RESERVED |
| fill_tag | input | 2 | Transactional tag: 0 free, 1 stable, 2 old, 3 new |
| fill_data | input | 16 | Line data |
| req_valid | input | 1 | A bus cycle from another node is present |
| req_kind | input | 3 | 0 read, 1 read-exclusive, 2 write-back, 3 transactional read, 4 transactional read-exclusive |
| req_addr | input | 8 | Line address of the bus cycle |
| txn_live | input | 1 | The local transaction is live |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_supply | output | 1 | A cache supplies data |
| rsp_busy | output | 1 | The cycle is refused |
| rsp_data | output | 16 | Supplied data, 0 when nothing is supplied |
| rsp_flush | output | 1 | Supplied data is modified and memory must capture it |
| rsp_cache | output | 1 | Some cache answered (data or busy) |
| rsp_mem | output | 1 | Memory must answer this cycle |

## Verification
The regular cache is loaded with lines in each of VALID, DIRTY and RESERVED and probed with shared and exclusive reads. Repeating a probe shows whether the state moved, because the flush flag appears only the first time and an invalidated line turns into a memory answer. The transactional cache holds stable, old and new copies of the same addresses and is probed with the transaction live and not live and with both plain and transactional kinds. This separates the stable-only view from the refusal path and from the committed-copy read. Write-backs, tag mismatches and a line present in both caches under a conflicting transactional cycle show that memory answers only when it should and that busy overrides data without disturbing any state.

// File: rtl/txsnoop_pkg.sv
package txsnoop_pkg;
  typedef enum logic [2:0] {
    K_RD   = 3'd0,
    K_RDX  = 3'd1,
    K_WB   = 3'd2,
    K_TRD  = 3'd3,
    K_TRDX = 3'd4
  } kind_e;

  localparam logic [1:0] S_INV = 2'd0;
  localparam logic [1:0] S_VAL = 2'd1;
  localparam logic [1:0] S_DRT = 2'd2;
  localparam logic [1:0] S_RSV = 2'd3;

  localparam logic [1:0] G_FREE   = 2'd0;
  localparam logic [1:0] G_STABLE = 2'd1;
  localparam logic [1:0] G_OLD    = 2'd2;
  localparam logic [1:0] G_NEW    = 2'd3;

  function automatic logic kind_shared(input logic [2:0] k);
    return (k == K_RD) || (k == K_TRD);
  endfunction

  function automatic logic kind_excl(input logic [2:0] k);
    return (k == K_RDX) || (k == K_TRDX);
  endfunction

  function automatic logic kind_txn(input logic [2:0] k);
    return (k == K_TRD) || (k == K_TRDX);
  endfunction
endpackage

// File: rtl/txsnoop_reg_array.sv
module txsnoop_reg_array
  import txsnoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              lk_valid,
  input  logic [2:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              upd_en,
  output logic              hit_supply,
  output logic              hit_dirty,
  output logic [DATA_W-1:0] hit_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0]        st_q [LINES];
  logic [TAG_W-1:0]  tg_q [LINES];
  logic [DATA_W-1:0] dt_q [LINES];

  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  fl_idx;
  logic [1:0]        st_nxt;
  logic              lk_rd;

  assign lk_idx = lk_addr[IDX_W-1:0];
  assign fl_idx = fill_addr[IDX_W-1:0];
  assign lk_rd  = kind_shared(lk_kind) || kind_excl(lk_kind);

  always_comb begin
    hit_supply = lk_valid && lk_rd && (st_q[lk_idx] != S_INV) &&
                 (tg_q[lk_idx] == lk_addr[ADDR_W-1:IDX_W]);
    hit_dirty  = hit_supply && kind_shared(lk_kind) && (st_q[lk_idx] == S_DRT);
    hit_data   = hit_supply ? dt_q[lk_idx] : '0;
    st_nxt     = kind_shared(lk_kind) ? S_VAL : S_INV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= S_INV;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_we && (fl_idx == IDX_W'(i))) begin
          st_q[i] <= fill_state;
        end else if (upd_en && hit_supply && (lk_idx == IDX_W'(i))) begin
          st_q[i] <= st_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (fill_we && (fl_idx == IDX_W'(i))) begin
        tg_q[i] <= fill_addr[ADDR_W-1:IDX_W];
        dt_q[i] <= fill_data;
      end
    end
  end
endmodule

// File: rtl/txsnoop_txn_array.sv
module txsnoop_txn_array
  import txsnoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [$clog2(LINES)-1:0] fill_slot,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic [1:0]        fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              lk_valid,
  input  logic [2:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              txn_live,
  input  logic              upd_en,
  output logic              hit_supply,
  output logic              hit_busy,
  output logic              hit_dirty,
  output logic [DATA_W-1:0] hit_data
);
  localparam int IDX_W = $clog2(LINES);

  logic [1:0]        st_q [LINES];
  logic [1:0]        tg_q [LINES];
  logic [ADDR_W-1:0] ad_q [LINES];
  logic [DATA_W-1:0] dt_q [LINES];

  logic [LINES-1:0]  held, stab, copy, nonval;
  logic              txmode, lk_rd, pick_any;
  logic [IDX_W-1:0]  sel;
  logic              upd_line;
  logic [1:0]        st_nxt, tg_nxt;

  for (genvar g = 0; g < LINES; g++) begin : g_match
    assign held[g]   = (tg_q[g] != G_FREE) && (st_q[g] != S_INV) && (ad_q[g] == lk_addr);
    assign stab[g]   = held[g] && (tg_q[g] == G_STABLE);
    assign copy[g]   = held[g] && ((tg_q[g] == G_STABLE) || (tg_q[g] == G_OLD));
    assign nonval[g] = held[g] && (st_q[g] != S_VAL);
  end

  assign txmode = txn_live && kind_txn(lk_kind);
  assign lk_rd  = kind_shared(lk_kind) || kind_excl(lk_kind);

  always_comb begin
    sel      = '0;
    pick_any = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (txmode ? copy[i] : stab[i]) begin
        sel      = IDX_W'(i);
        pick_any = 1'b1;
      end
    end
  end

  always_comb begin
    hit_supply = 1'b0;
    hit_busy   = 1'b0;
    upd_line   = 1'b0;
    if (lk_valid && lk_rd) begin
      if (txmode) begin
        if (|held) begin
          if ((lk_kind == K_TRD) && !(|nonval) && pick_any) hit_supply = 1'b1;
          else hit_busy = 1'b1;
        end
      end else if (pick_any) begin
        hit_supply = 1'b1;
        upd_line   = 1'b1;
      end
    end
    hit_dirty = hit_supply && !txmode && kind_shared(lk_kind) && (st_q[sel] == S_DRT);
    hit_data  = hit_supply ? dt_q[sel] : '0;
    st_nxt    = kind_shared(lk_kind) ? S_VAL : S_INV;
    tg_nxt    = kind_shared(lk_kind) ? G_STABLE : G_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i] <= S_INV;
        tg_q[i] <= G_FREE;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_we && (fill_slot == IDX_W'(i))) begin
          st_q[i] <= fill_state;
          tg_q[i] <= fill_tag;
        end else if (upd_en && upd_line && (sel == IDX_W'(i))) begin
          st_q[i] <= st_nxt;
          tg_q[i] <= tg_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (fill_we && (fill_slot == IDX_W'(i))) begin
        ad_q[i] <= fill_addr;
        dt_q[i] <= fill_data;
      end
    end
  end
endmodule

// File: rtl/txsnoop_merge.sv
module txsnoop_merge
  import txsnoop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              reg_supply,
  input  logic              reg_dirty,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              tx_supply,
  input  logic              tx_busy,
  input  logic              tx_dirty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              upd_en,
  output logic              rsp_valid,
  output logic              rsp_supply,
  output logic              rsp_busy,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_flush,
  output logic              rsp_cache,
  output logic              rsp_mem
);
  logic              n_supply, n_busy, n_flush, n_cache, n_mem, n_answerable;
  logic [DATA_W-1:0] n_data;

  assign upd_en = req_valid && !tx_busy;

  always_comb begin
    n_busy       = req_valid && tx_busy;
    n_supply     = req_valid && !tx_busy && (reg_supply || tx_supply);
    n_data       = !n_supply ? '0 : (reg_supply ? reg_data : tx_data);
    n_flush      = n_supply && (reg_supply ? reg_dirty : tx_dirty);
    n_cache      = n_busy || n_supply;
    n_answerable = kind_shared(req_kind) || kind_excl(req_kind);
    n_mem        = req_valid && ((req_kind == K_WB) || (n_answerable && !n_cache));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_supply <= 1'b0;
      rsp_busy   <= 1'b0;
      rsp_data   <= '0;
      rsp_flush  <= 1'b0;
      rsp_cache  <= 1'b0;
      rsp_mem    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_supply <= n_supply;
      rsp_busy   <= n_busy;
      rsp_data   <= n_data;
      rsp_flush  <= n_flush;
      rsp_cache  <= n_cache;
      rsp_mem    <= n_mem;
    end
  end
endmodule

// File: rtl/txsnoop_responder.sv
module txsnoop_responder
  import txsnoop_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int REG_LINES = 4,
  parameter int TX_LINES  = 4,
  localparam int SLOT_W   = $clog2(TX_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic              fill_txn,
  input  logic [SLOT_W-1:0] fill_slot,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic [1:0]        fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              txn_live,
  output logic              rsp_valid,
  output logic              rsp_supply,
  output logic              rsp_busy,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_flush,
  output logic              rsp_cache,
  output logic              rsp_mem
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              reg_supply, reg_dirty, tx_supply, tx_busy, tx_dirty, upd_en;
  logic [DATA_W-1:0] reg_data, tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  txsnoop_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(REG_LINES)) u_reg (
    .clk(clk), .rst_n(rst_s),
    .fill_we(fill_en && !fill_txn), .fill_addr(fill_addr), .fill_state(fill_state),
    .fill_data(fill_data),
    .lk_valid(req_valid), .lk_kind(req_kind), .lk_addr(req_addr), .upd_en(upd_en),
    .hit_supply(reg_supply), .hit_dirty(reg_dirty), .hit_data(reg_data)
  );

  txsnoop_txn_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(TX_LINES)) u_txn (
    .clk(clk), .rst_n(rst_s),
    .fill_we(fill_en && fill_txn), .fill_slot(fill_slot), .fill_addr(fill_addr),
    .fill_state(fill_state), .fill_tag(fill_tag), .fill_data(fill_data),
    .lk_valid(req_valid), .lk_kind(req_kind), .lk_addr(req_addr), .txn_live(txn_live),
    .upd_en(upd_en),
    .hit_supply(tx_supply), .hit_busy(tx_busy), .hit_dirty(tx_dirty), .hit_data(tx_data)
  );

  txsnoop_merge #(.DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst_n(rst_s),
    .req_valid(req_valid), .req_kind(req_kind),
    .reg_supply(reg_supply), .reg_dirty(reg_dirty), .reg_data(reg_data),
    .tx_supply(tx_supply), .tx_busy(tx_busy), .tx_dirty(tx_dirty), .tx_data(tx_data),
    .upd_en(upd_en),
    .rsp_valid(rsp_valid), .rsp_supply(rsp_supply), .rsp_busy(rsp_busy),
    .rsp_data(rsp_data), .rsp_flush(rsp_flush), .rsp_cache(rsp_cache), .rsp_mem(rsp_mem)
  );
endmodule

// File: rtl/txsnoop_responder_chk.sv
module txsnoop_responder_chk (
  input logic       clk,
  input logic       rst_s,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       txn_live,
  input logic       rsp_valid,
  input logic       rsp_supply,
  input logic       rsp_busy,
  input logic       rsp_flush,
  input logic       rsp_cache,
  input logic       rsp_mem
);
  // R2: a response is always the answer to a request of the cycle before
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_valid |-> $past(req_valid));

  // R2: an idle bus cycle produces no response and no memory answer
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !req_valid |=> (!rsp_valid && !rsp_mem && !rsp_cache));

  // R9: write-backs go to memory and never to a cache
  a_r9_wb_to_mem: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && req_kind == 3'd2) |=> (rsp_mem && !rsp_cache));

  // R8: refusal needs a live transaction and a transactional cycle
  a_r8_busy_needs_live_txn: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && !(txn_live && (req_kind == 3'd3 || req_kind == 3'd4))) |=> !rsp_busy);

  // R10: exclusive reads never ask memory to capture data
  a_r10_no_flush_on_excl: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && (req_kind == 3'd1 || req_kind == 3'd4)) |=> !rsp_flush);

  // R11: a refusal carries no data and keeps memory silent
  a_r11_busy_beats_data: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_busy |-> (!rsp_supply && !rsp_mem && rsp_cache));
endmodule

bind txsnoop_responder txsnoop_responder_chk u_chk (
  .clk(clk), .rst_s(rst_s), .req_valid(req_valid), .req_kind(req_kind),
  .txn_live(txn_live), .rsp_valid(rsp_valid), .rsp_supply(rsp_supply),
  .rsp_busy(rsp_busy), .rsp_flush(rsp_flush), .rsp_cache(rsp_cache), .rsp_mem(rsp_mem)
);

// File: tb/txsnoop_responder_test.sv
`timescale 1ns/1ps
module txsnoop_responder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fill_en, fill_txn;
  logic [1:0]  fill_slot, fill_state, fill_tag;
  logic [7:0]  fill_addr, req_addr;
  logic [15:0] fill_data;
  logic        req_valid, txn_live;
  logic [2:0]  req_kind;
  logic        rsp_valid, rsp_supply, rsp_busy, rsp_flush, rsp_cache, rsp_mem;
  logic [15:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic        c_valid, c_supply, c_busy, c_flush, c_cache, c_mem;
  logic [15:0] c_data;

  localparam logic [2:0] RD = 3'd0, RDX = 3'd1, WB = 3'd2, TRD = 3'd3, TRDX = 3'd4;
  localparam logic [1:0] INV = 2'd0, VAL = 2'd1, DRT = 2'd2, RSV = 2'd3;
  localparam logic [1:0] FREE = 2'd0, STAB = 2'd1, OLD = 2'd2, NEWT = 2'd3;

  always #4 clk = ~clk;

  txsnoop_responder uut (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_txn(fill_txn),
    .fill_slot(fill_slot), .fill_addr(fill_addr), .fill_state(fill_state),
    .fill_tag(fill_tag), .fill_data(fill_data), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .txn_live(txn_live),
    .rsp_valid(rsp_valid), .rsp_supply(rsp_supply), .rsp_busy(rsp_busy),
    .rsp_data(rsp_data), .rsp_flush(rsp_flush), .rsp_cache(rsp_cache), .rsp_mem(rsp_mem)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_reg(input logic [7:0] a, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    fill_en = 1'b1; fill_txn = 1'b0; fill_addr = a; fill_state = s; fill_data = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic fill_tx(input logic [1:0] slot, input logic [7:0] a, input logic [1:0] s,
                         input logic [1:0] t, input logic [15:0] d);
    @(negedge clk);
    fill_en = 1'b1; fill_txn = 1'b1; fill_slot = slot; fill_addr = a;
    fill_state = s; fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic snoop(input logic [2:0] k, input logic [7:0] a, input logic live);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; txn_live = live;
    @(posedge clk);
    #2;
    c_valid = rsp_valid; c_supply = rsp_supply; c_busy = rsp_busy; c_data = rsp_data;
    c_flush = rsp_flush; c_cache = rsp_cache; c_mem = rsp_mem;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // expected: supply, busy, flush, mem, data
  task automatic expect_rsp(input string req, input logic s, input logic b,
                            input logic f, input logic m, input logic [15:0] d);
    chk(req, "valid", c_valid, 1);
    chk(req, "supply", c_supply, s);
    chk(req, "busy", c_busy, b);
    chk(req, "flush", c_flush, f);
    chk(req, "mem", c_mem, m);
    chk(req, "cache", c_cache, s | b);
    chk(req, "data", c_data, d);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "valid in reset", rsp_valid, 0);
    chk("R1", "mem in reset", rsp_mem, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "valid after release", rsp_valid, 0);
    chk("R1", "cache after release", rsp_cache, 0);
    chk("R1", "busy after release", rsp_busy, 0);
  endtask

  task automatic t_regular_read;
    fill_reg(8'h10, VAL, 16'hA010);
    fill_reg(8'h12, DRT, 16'hB012);
    fill_reg(8'h13, RSV, 16'hC013);
    snoop(RD, 8'h10, 1'b0);  expect_rsp("R3", 1, 0, 0, 0, 16'hA010);
    snoop(RD, 8'h10, 1'b0);  expect_rsp("R3", 1, 0, 0, 0, 16'hA010);
    // R2: the cycle after a response with no request is silent
    @(posedge clk); #2;
    chk("R2", "idle valid", rsp_valid, 0);
    chk("R2", "idle mem", rsp_mem, 0);
    snoop(TRD, 8'h12, 1'b0); expect_rsp("R10", 1, 0, 1, 0, 16'hB012);
    snoop(RD, 8'h12, 1'b0);  expect_rsp("R3", 1, 0, 0, 0, 16'hB012);
    snoop(RD, 8'h13, 1'b0);  expect_rsp("R3", 1, 0, 0, 0, 16'hC013);
  endtask

  task automatic t_regular_excl;
    snoop(RDX, 8'h13, 1'b0); expect_rsp("R4", 1, 0, 0, 0, 16'hC013);
    snoop(RD, 8'h13, 1'b0);  expect_rsp("R4", 0, 0, 0, 1, 16'h0);
    fill_reg(8'h12, DRT, 16'hD012);
    snoop(TRDX, 8'h12, 1'b0); expect_rsp("R10", 1, 0, 0, 0, 16'hD012);
    snoop(TRD, 8'h12, 1'b0);  expect_rsp("R4", 0, 0, 0, 1, 16'h0);
  endtask

  task automatic t_miss_and_wb;
    snoop(RD, 8'h50, 1'b0);  expect_rsp("R5", 0, 0, 0, 1, 16'h0);
    snoop(RDX, 8'h77, 1'b1); expect_rsp("R5", 0, 0, 0, 1, 16'h0);
    snoop(WB, 8'h10, 1'b0);  expect_rsp("R9", 0, 0, 0, 1, 16'h0);
    snoop(RD, 8'h10, 1'b0);  expect_rsp("R9", 1, 0, 0, 0, 16'hA010);
  endtask

  task automatic t_txn_not_live;
    fill_tx(2'd0, 8'h80, VAL, STAB, 16'h1080);
    fill_tx(2'd1, 8'h81, DRT, NEWT, 16'h2081);
    fill_tx(2'd2, 8'h81, VAL, OLD,  16'h3081);
    fill_tx(2'd3, 8'h90, VAL, OLD,  16'h4090);
    snoop(RD, 8'h80, 1'b0);  expect_rsp("R6", 1, 0, 0, 0, 16'h1080);
    snoop(RD, 8'h81, 1'b0);  expect_rsp("R6", 0, 0, 0, 1, 16'h0);
    snoop(TRD, 8'h81, 1'b0); expect_rsp("R6", 0, 0, 0, 1, 16'h0);
  endtask

  task automatic t_txn_live;
    snoop(TRD, 8'h80, 1'b1);  expect_rsp("R7", 1, 0, 0, 0, 16'h1080);
    snoop(TRD, 8'h90, 1'b1);  expect_rsp("R7", 1, 0, 0, 0, 16'h4090);
    snoop(TRD, 8'h81, 1'b1);  expect_rsp("R8", 0, 1, 0, 0, 16'h0);
    snoop(TRDX, 8'h80, 1'b1); expect_rsp("R8", 0, 1, 0, 0, 16'h0);
    snoop(RD, 8'h80, 1'b1);   expect_rsp("R8", 1, 0, 0, 0, 16'h1080);
    snoop(RDX, 8'h80, 1'b1);  expect_rsp("R6", 1, 0, 0, 0, 16'h1080);
    snoop(TRD, 8'h80, 1'b1);  expect_rsp("R6", 0, 0, 0, 1, 16'h0);
  endtask

  task automatic t_busy_wins;
    fill_reg(8'h81, VAL, 16'h5081);
    snoop(TRD, 8'h81, 1'b1); expect_rsp("R11", 0, 1, 0, 0, 16'h0);
    snoop(RD, 8'h81, 1'b0);  expect_rsp("R11", 1, 0, 0, 0, 16'h5081);
  endtask

  task automatic t_txn_dirty_stable;
    fill_tx(2'd0, 8'h84, DRT, STAB, 16'h6084);
    snoop(RD, 8'h84, 1'b0);  expect_rsp("R10", 1, 0, 1, 0, 16'h6084);
    snoop(RD, 8'h84, 1'b0);  expect_rsp("R6", 1, 0, 0, 0, 16'h6084);
  endtask

  initial begin
    rst_n = 1'b0; fill_en = 1'b0; fill_txn = 1'b0; fill_slot = '0; fill_addr = '0;
    fill_state = '0; fill_tag = '0; fill_data = '0; req_valid = 1'b0; req_kind = '0;
    req_addr = '0; txn_live = 1'b0;
    t_reset();
    t_regular_read();
    t_regular_excl();
    t_miss_and_wb();
    t_txn_not_live();
    t_txn_live();
    t_busy_wins();
    t_txn_dirty_stable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule